// File: doc/BRIEF.md
# Eight-Channel DAC Command Controller

This block sits behind a serial front end that has already assembled 16-bit command words. One word arrives with each single-cycle `cmd_valid` strobe. The block keeps a data register and an output latch for each of eight 8-bit DAC channels, A to H. The latched codes drive the converters. An operating mode decides whether a plain channel write reaches the output at once or waits in the data register. Three group commands move register contents to the outputs in either mode. Words meant for power management are handed on unchanged to a separate block.

Every command takes effect on the clock edge that samples its strobe. All latch, register and mode changes from one word therefore become visible together in the following cycle.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: After reset every data register and output latch is zero, `wt_mode` is 0 (register-only mode) and `pd_valid` is 0.
- R2: A word with bit 15 clear is a channel write. Bits 14:12 pick the channel (0 = A through 7 = H) and bits 11:4 carry the code. In register-only mode only that channel's data register changes, and no output moves.
- R3: In write-through mode a channel write loads both the data register and the output latch of the picked channel, and no other channel changes.
- R4: Top nibble 1000 selects register-only mode (`wt_mode`=0) and 1001 selects write-through mode (`wt_mode`=1). The mode holds until the other of these two codes arrives.
- R5: Top nibble 1010 copies the data register into the output latch of every channel whose bit in 7:0 is 1 (bit 0 = A through bit 7 = H). Unselected outputs keep their values.
- R6: Top nibble 1011 loads channel A's register and output from bits 11:4, and in the same cycle copies channels B to H from their registers to their outputs. The mode does not change.
- R7: Top nibble 1100 writes bits 11:4 into all eight data registers and all eight output latches at once.
- R8: Top nibbles 1101, 1110 and 1111 change no register, output or mode. The word appears on `pd_word` with `pd_valid` high for exactly one cycle, in the cycle after the strobe.
- R9: All changes from a command appear in the cycle after its strobe. With `cmd_valid` low, nothing changes, whatever is on `cmd_word`.
- R10: Bits 3:0 of a channel write, channel-A write or broadcast have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe marking a valid command word |
| cmd_word | input | 16 | Command word |
| code_out | output | 64 | Latched DAC codes, channel i in bits 8i+7:8i (A = 0) |
| wt_mode | output | 1 | 1 = write-through mode, 0 = register-only mode |
| pd_valid | output | 1 | One-cycle strobe for a forwarded power-down word |
| pd_word | output | 16 | Forwarded power-down word |

## Verification
The bench targets the cases where a wrong design would move outputs at the wrong time:
- A channel write in register-only mode that leaked to the output would show a changed latch at once.
- A register written in one mode and revealed only later by a selective update or a channel-A write would expose a register that was never stored, or one that was copied from the wrong channel.
- The channel-A write checks that the mode survives it, and that B to H pick up their stored registers rather than their old outputs.
- Power-down words, noise on an idle bus and junk in the low nibble are checked for the absence of any effect.
- Mask patterns with single bits, all bits and no bits catch an off-by-one in the channel ordering.

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl #(
  parameter int NCH = 8,
  parameter int CW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [15:0]       cmd_word,
  output logic [NCH*CW-1:0] code_out,
  output logic              wt_mode,
  output logic              pd_valid,
  output logic [15:0]       pd_word
);
  localparam int SW = $clog2(NCH);

  logic [CW-1:0] data_r [NCH];
  logic [CW-1:0] out_r  [NCH];
  logic [3:0]    op;
  logic [CW-1:0] code;
  logic [SW-1:0] sel;
  logic          is_pd;

  assign op    = cmd_word[15:12];
  assign code  = cmd_word[11:4];
  assign sel   = cmd_word[12 +: SW];
  assign is_pd = op == 4'b1101 || op == 4'b1110 || op == 4'b1111;

  for (genvar g = 0; g < NCH; g++) begin : g_pack
    assign code_out[g*CW +: CW] = out_r[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        data_r[i] <= '0;
        out_r[i]  <= '0;
      end
      wt_mode  <= 1'b0;
      pd_valid <= 1'b0;
      pd_word  <= '0;
    end else begin
      pd_valid <= 1'b0;
      if (cmd_valid) begin
        if (!cmd_word[15]) begin
          data_r[sel] <= code;
          if (wt_mode) out_r[sel] <= code;
        end else begin
          case (op)
            4'b1000: wt_mode <= 1'b0;
            4'b1001: wt_mode <= 1'b1;
            4'b1010:
              for (int i = 0; i < NCH; i++)
                if (cmd_word[i]) out_r[i] <= data_r[i];
            4'b1011: begin
              data_r[0] <= code;
              out_r[0]  <= code;
              for (int i = 1; i < NCH; i++) out_r[i] <= data_r[i];
            end
            4'b1100:
              for (int i = 0; i < NCH; i++) begin
                data_r[i] <= code;
                out_r[i]  <= code;
              end
            default: begin
              if (is_pd) begin
                pd_valid <= 1'b1;
                pd_word  <= cmd_word;
              end
            end
          endcase
        end
      end
    end
  end

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(code_out) && $stable(wt_mode) && !pd_valid);

  assert_wrm_no_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_word[15] && !wt_mode |=> $stable(code_out) && !wt_mode);

  assert_mode_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word[15:12] == 4'b1001 |=> wt_mode);

  assert_mode_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word[15:12] == 4'b1000 |=> !wt_mode);

  assert_cha_keeps_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word[15:12] == 4'b1011 |=>
      $stable(wt_mode) && code_out[CW-1:0] == $past(cmd_word[11:4]));

  assert_bcast_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word[15:12] == 4'b1100 |=> code_out == {NCH{$past(cmd_word[11:4])}});

  assert_pd_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word[15:13] == 3'b111 |=>
      $stable(code_out) && $stable(wt_mode) && pd_valid && pd_word == $past(cmd_word));

  assert_pd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pd_valid |=> !pd_valid || $past(cmd_valid));
endmodule

// File: tb/dac_cmd_ctrl_bench.sv
module dac_cmd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [63:0] code_out;
  logic        wt_mode;
  logic        pd_valid;
  logic [15:0] pd_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] m_reg [8];
  logic [7:0] m_out [8];
  logic       m_mode;
  logic       m_pdv;
  logic [15:0] m_pdw;

  always #2 clk = ~clk;

  dac_cmd_ctrl u_dac_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .code_out(code_out), .wt_mode(wt_mode), .pd_valid(pd_valid), .pd_word(pd_word)
  );

  function automatic string req_of(logic [15:0] w);
    if (!w[15]) return "R2/R3/R10";
    case (w[15:12])
      4'b1000, 4'b1001: return "R4";
      4'b1010: return "R5";
      4'b1011: return "R6/R10";
      4'b1100: return "R7/R10";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [63:0] pack_out();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = m_out[i];
    return v;
  endfunction

  task automatic model(logic [15:0] w);
    logic [7:0] c = w[11:4];
    m_pdv = 1'b0;
    if (!w[15]) begin
      m_reg[w[14:12]] = c;
      if (m_mode) m_out[w[14:12]] = c;
    end else begin
      case (w[15:12])
        4'b1000: m_mode = 1'b0;
        4'b1001: m_mode = 1'b1;
        4'b1010: for (int i = 0; i < 8; i++) if (w[i]) m_out[i] = m_reg[i];
        4'b1011: begin
          m_reg[0] = c; m_out[0] = c;
          for (int i = 1; i < 8; i++) m_out[i] = m_reg[i];
        end
        4'b1100: for (int i = 0; i < 8; i++) begin m_reg[i] = c; m_out[i] = c; end
        default: begin m_pdv = 1'b1; m_pdw = w; end
      endcase
    end
  endtask

  task automatic check(string req);
    logic [63:0] exp = pack_out();
    n_chk++;
    if (code_out !== exp || wt_mode !== m_mode || pd_valid !== m_pdv ||
        (m_pdv && pd_word !== m_pdw)) begin
      n_bad++;
      $display("FAIL %s: out=%h mode=%b pdv=%b pdw=%h expected out=%h mode=%b pdv=%b pdw=%h",
               req, code_out, wt_mode, pd_valid, pd_word, exp, m_mode, m_pdv, m_pdw);
    end
  endtask

  task automatic send(logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    model(w);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = 16'($urandom);
    check({req_of(w), "/R9"});
    m_pdv = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmd_word = 16'($urandom);
    end
    @(negedge clk);
    check("R9 idle");
  endtask

  function automatic logic [15:0] rand_word();
    int r = $urandom % 12;
    logic [15:0] w = 16'($urandom);
    if (r < 5) w[15] = 1'b0;
    else w[15:12] = 4'(4'b1000 + (r - 5) % 8);
    return w;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin m_reg[i] = '0; m_out[i] = '0; end
    m_mode = 1'b0; m_pdv = 1'b0; m_pdw = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset");

    send(16'h25A3);
    send(16'hA000);
    send(16'hA004);
    send(16'h7FF0);
    send(16'hA0FF);
    send(16'h1C37);
    send(16'h9000);
    send(16'h3ABF);
    send(16'h6126);
    send(16'hB99F);
    send(16'h4440);
    send(16'hA010);
    send(16'hCE7A);
    send(16'hDFFF);
    send(16'hE0AA);
    send(16'hF123);
    send(16'h8000);
    send(16'h0330);
    send(16'hB000);
    send(16'hA080);
    idle(5);

    for (int n = 0; n < 1500; n++) begin
      send(rand_word());
      if (n % 100 == 0) idle(3);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule